// File: doc/BRIEF.md
# SDRAM Self-Refresh Entry and Exit Sequencer

This block moves one memory rank into self-refresh and brings it back out on behalf of a memory controller. The controller pulses an entry request. Once every bank reports idle, the sequencer issues a refresh command with the clock-enable pin driven low. It keeps the memory clock running for a set margin and then drops its clock-run qualifier, so that the clock source may stop.

When the controller pulses an exit request, the sequencer restarts the clock first. After a lead margin it raises the clock-enable pin. It then holds the command bus at no-operation for a fixed window of 200 cycles by default. This window covers completion of any internal refresh and relock of the delay-locked loop. A single-cycle ready pulse tells the controller that normal traffic, reads included, may resume.

Requests that arrive at awkward moments are resolved inside the block. An entry request made while banks are still open waits until they close. An exit request made while the entry steps are still running is remembered and acted on as soon as the rank is asleep.

Top module: `srx_sequencer`

## Requirements
- R1: While reset is held, and after it is released with no request, `cke_o` is 1, `cmd_o` is NOP, `clk_run_o` is 1 and `busy_o` and `ready_o` are 0. The command encoding is {cs_n, ras_n, cas_n, we_n}: NOP = 4'b0111, REFRESH = 4'b0001, DESELECT = 4'b1111.
- R2: When the sequencer is idle and an entry request is seen with `banks_idle_i` high, the next cycle shows REFRESH on `cmd_o` with `cke_o` 0. REFRESH lasts exactly one cycle.
- R3: An entry request made while `banks_idle_i` is low is kept pending. The REFRESH cycle follows the first cycle in which `banks_idle_i` is high.
- R4: After the REFRESH cycle, `clk_run_o` stays 1 with `cke_o` 0 for ENTRY_HOLD_CYC cycles (default 1) before it falls to 0.
- R5: While the rank is asleep, `cke_o` is 0, `clk_run_o` is 0 and `cmd_o` is DESELECT, until an exit request is acted on.
- R6: On exit, `clk_run_o` returns to 1 for EXIT_LEAD_CYC cycles (default 1) with `cke_o` still 0. Only then does `cke_o` rise.
- R7: From the cycle `cke_o` rises, it stays 1 and `cmd_o` stays NOP for exactly XS_CYC cycles (default 200). This also satisfies a minimum of four cycles with clock enable high.
- R8: `busy_o` is 1 from the REFRESH cycle through the last cycle of the NOP window. `ready_o` is high for the single cycle that follows the window, while `busy_o` is 0.
- R9: An exit request made during the REFRESH cycle or the entry clock margin is queued. The exit then starts one cycle after the rank falls asleep, with no further request.
- R10: An exit request while idle, and any request during the NOP window or an entry request while asleep, has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req_i | input | 1 | One-cycle request to enter self-refresh |
| exit_req_i | input | 1 | One-cycle request to leave self-refresh |
| banks_idle_i | input | 1 | High when every bank of the rank is precharged |
| cke_o | output | 1 | Clock-enable pin to the memory |
| cmd_o | output | 4 | Command bus {cs_n, ras_n, cas_n, we_n} |
| clk_run_o | output | 1 | High when the memory clock must be running and stable |
| busy_o | output | 1 | High from entry until the exit window ends |
| ready_o | output | 1 | One-cycle pulse: normal commands allowed again |

## Verification
The checker assumes that the controller issues normal commands only when `busy_o` is low. It needs no assumption about request timing, because the block itself filters stray requests. It also assumes that reset is released synchronously, so that the clock-enable high-time counter begins in its saturated state. The stimulus applies requests as single-cycle pulses and toggles bank idleness only between steps. It places deliberate stray requests in the idle state, the sleep state and the middle of the exit window, which keeps every property on its defined paths.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_ENTER = 3'd1,
    ST_HOLD  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_WAKE  = 3'd4,
    ST_XWAIT = 3'd5
  } srx_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP     = 4'b0111;
  localparam logic [3:0] CMD_REFRESH = 4'b0001;
  localparam logic [3:0] CMD_DESEL   = 4'b1111;

endpackage

// File: rtl/srx_rst_sync.sv
module srx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/srx_phase_timer.sv
module srx_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart_i,
  input  logic          count_en_i,
  output logic [CW-1:0] cnt_o
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (restart_i)       cnt_d = '0;
    else if (count_en_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/srx_out_decode.sv
module srx_out_decode
  import srx_pkg::*;
(
  input  srx_state_e state_i,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       clk_run_o,
  output logic       busy_o
);

  always_comb begin
    cke_o     = 1'b0;
    cmd_o     = CMD_DESEL;
    clk_run_o = 1'b1;
    busy_o    = 1'b1;
    unique case (state_i)
      ST_IDLE: begin
        cke_o  = 1'b1;
        cmd_o  = CMD_NOP;
        busy_o = 1'b0;
      end
      ST_ENTER: cmd_o = CMD_REFRESH;
      ST_HOLD:  cmd_o = CMD_DESEL;
      ST_SLEEP: clk_run_o = 1'b0;
      ST_WAKE:  cmd_o = CMD_NOP;
      ST_XWAIT: begin
        cke_o = 1'b1;
        cmd_o = CMD_NOP;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/srx_sequencer.sv
module srx_sequencer
  import srx_pkg::*;
#(
  parameter int ENTRY_HOLD_CYC = 1,
  parameter int EXIT_LEAD_CYC  = 1,
  parameter int XS_CYC         = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enter_req_i,
  input  logic       exit_req_i,
  input  logic       banks_idle_i,
  output logic       cke_o,
  output logic [3:0] cmd_o,
  output logic       clk_run_o,
  output logic       busy_o,
  output logic       ready_o
);

  localparam int MAX_A = (ENTRY_HOLD_CYC > EXIT_LEAD_CYC) ? ENTRY_HOLD_CYC : EXIT_LEAD_CYC;
  localparam int MAX_C = (MAX_A > XS_CYC) ? MAX_A : XS_CYC;
  localparam int CW    = $clog2(MAX_C) + 1;
  localparam logic [CW-1:0] LIM_HOLD = CW'(ENTRY_HOLD_CYC - 1);
  localparam logic [CW-1:0] LIM_LEAD = CW'(EXIT_LEAD_CYC - 1);
  localparam logic [CW-1:0] LIM_XS   = CW'(XS_CYC - 1);

  logic          rst_n_s;
  srx_state_e    state_q, state_d;
  logic          enter_pend_q, enter_pend_d;
  logic          exit_pend_q, exit_pend_d;
  logic          ready_q, ready_d;
  logic [CW-1:0] cnt;
  logic          restart, count_en, go, wake;

  srx_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  srx_phase_timer #(.CW(CW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .restart_i  (restart),
    .count_en_i (count_en),
    .cnt_o      (cnt)
  );

  assign go       = (enter_req_i | enter_pend_q) & banks_idle_i;
  assign wake     = exit_req_i | exit_pend_q;
  assign count_en = (state_q == ST_HOLD) || (state_q == ST_WAKE) || (state_q == ST_XWAIT);
  assign restart  = (state_d != state_q);

  // next-state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (go) state_d = ST_ENTER;
      ST_ENTER: state_d = ST_HOLD;
      ST_HOLD:  if (cnt == LIM_HOLD) state_d = ST_SLEEP;
      ST_SLEEP: if (wake) state_d = ST_WAKE;
      ST_WAKE:  if (cnt == LIM_LEAD) state_d = ST_XWAIT;
      ST_XWAIT: if (cnt == LIM_XS) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // request capture
  always_comb begin
    enter_pend_d = 1'b0;
    exit_pend_d  = 1'b0;
    if (state_q == ST_IDLE)
      enter_pend_d = (enter_req_i | enter_pend_q) & ~banks_idle_i;
    if ((state_q == ST_ENTER) || (state_q == ST_HOLD))
      exit_pend_d = wake;
    else if (state_q == ST_SLEEP)
      exit_pend_d = 1'b0;
    ready_d = (state_q == ST_XWAIT) && (state_d == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q      <= ST_IDLE;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
      ready_q      <= 1'b0;
    end else begin
      state_q      <= state_d;
      enter_pend_q <= enter_pend_d;
      exit_pend_q  <= exit_pend_d;
      ready_q      <= ready_d;
    end
  end

  srx_out_decode u_dec (
    .state_i   (state_q),
    .cke_o     (cke_o),
    .cmd_o     (cmd_o),
    .clk_run_o (clk_run_o),
    .busy_o    (busy_o)
  );

  assign ready_o = ready_q;

endmodule

// File: rtl/srx_sequencer_chk.sv
module srx_sequencer_chk
  import srx_pkg::*;
#(
  parameter int XS_CYC       = 200,
  parameter int CKE_MIN_HIGH = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cke_o,
  input logic [3:0] cmd_o,
  input logic       clk_run_o,
  input logic       busy_o,
  input logic       ready_o
);

  localparam int HW = $clog2(XS_CYC + 1);
  localparam logic [HW-1:0] HI_SAT = HW'(XS_CYC);

  logic [HW-1:0] hi_cnt;

  // cycles cke has been high, saturating at the window length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            hi_cnt <= HI_SAT;
    else if (!cke_o)       hi_cnt <= '0;
    else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + 1'b1;
  end

  assert_refresh_cke_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REFRESH) |-> !cke_o);

  assert_refresh_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_o == CMD_REFRESH) |=> (cmd_o != CMD_REFRESH));

  assert_clock_margin_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_run_o) |-> (!cke_o && !$past(cke_o) && $past(cmd_o) != CMD_REFRESH));

  assert_sleep_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_run_o |-> (!cke_o && cmd_o == CMD_DESEL));

  assert_clock_before_cke_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke_o) |-> $past(clk_run_o));

  assert_nop_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o && hi_cnt < HI_SAT) |-> (cmd_o == CMD_NOP));

  assert_cke_min_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke_o) |-> (int'($past(hi_cnt)) >= CKE_MIN_HIGH));

  assert_ready_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o);

  assert_ready_after_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (!busy_o && $past(busy_o) && hi_cnt == HI_SAT));

endmodule

bind srx_sequencer srx_sequencer_chk #(.XS_CYC(XS_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cke_o     (cke_o),
  .cmd_o     (cmd_o),
  .clk_run_o (clk_run_o),
  .busy_o    (busy_o),
  .ready_o   (ready_o)
);

// File: tb/tb_srx_sequencer.sv
module tb_srx_sequencer;

  localparam logic [3:0] NOP = 4'b0111;
  localparam logic [3:0] REF = 4'b0001;
  localparam logic [3:0] DES = 4'b1111;

  typedef struct packed {
    logic [8:0] reps;
    logic       en;
    logic       ex;
    logic       idl;
    logic       cke;
    logic [3:0] cmd;
    logic       clkr;
    logic       busy;
    logic       rdy;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 21;
  // inputs applied before an edge; outputs expected after that edge
  localparam vec_t VEC [NV] = '{
    '{9'd1,   1'b1, 1'b0, 1'b0, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 request held
    '{9'd3,   1'b0, 1'b0, 1'b0, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 4'd3},  // R3 still pending
    '{9'd1,   1'b0, 1'b0, 1'b1, 1'b0, REF, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 refresh, cke low
    '{9'd1,   1'b0, 1'b1, 1'b1, 1'b0, DES, 1'b1, 1'b1, 1'b0, 4'd4},  // R4 clock margin, R9 exit queued
    '{9'd1,   1'b0, 1'b0, 1'b1, 1'b0, DES, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 asleep
    '{9'd1,   1'b0, 1'b0, 1'b1, 1'b0, NOP, 1'b1, 1'b1, 1'b0, 4'd9},  // R9 queued exit, R6 lead
    '{9'd200, 1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b1, 1'b0, 4'd7},  // R7 NOP window
    '{9'd1,   1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b0, 1'b1, 4'd8},  // R8 ready pulse
    '{9'd2,   1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 4'd8},  // R8 pulse ends
    '{9'd1,   1'b0, 1'b1, 1'b1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 4'd10}, // R10 exit while idle
    '{9'd2,   1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 4'd10},
    '{9'd1,   1'b1, 1'b0, 1'b1, 1'b0, REF, 1'b1, 1'b1, 1'b0, 4'd2},  // R2 direct entry
    '{9'd1,   1'b0, 1'b0, 1'b1, 1'b0, DES, 1'b1, 1'b1, 1'b0, 4'd4},
    '{9'd6,   1'b0, 1'b0, 1'b1, 1'b0, DES, 1'b0, 1'b1, 1'b0, 4'd5},  // R5 stays asleep
    '{9'd1,   1'b1, 1'b0, 1'b1, 1'b0, DES, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 enter while asleep
    '{9'd1,   1'b0, 1'b1, 1'b1, 1'b0, NOP, 1'b1, 1'b1, 1'b0, 4'd6},  // R6 clock first
    '{9'd100, 1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b1, 1'b0, 4'd7},
    '{9'd1,   1'b1, 1'b1, 1'b1, 1'b1, NOP, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 requests in window
    '{9'd99,  1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b1, 1'b0, 4'd7},
    '{9'd1,   1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b0, 1'b1, 4'd8},
    '{9'd3,   1'b0, 1'b0, 1'b1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 4'd10}  // R10 no late entry
  };

  logic       clk, rst_n, enter_req, exit_req, banks_idle;
  logic       cke, clk_run, busy, ready;
  logic [3:0] cmd;
  int         n_tests, n_fail;
  bit         done;

  srx_sequencer dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_req_i  (enter_req),
    .exit_req_i   (exit_req),
    .banks_idle_i (banks_idle),
    .cke_o        (cke),
    .cmd_o        (cmd),
    .clk_run_o    (clk_run),
    .busy_o       (busy),
    .ready_o      (ready)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input logic e_cke, input logic [3:0] e_cmd, input logic e_clk,
                       input logic e_busy, input logic e_rdy, input int req);
    logic [7:0] act, exp;
    act = {cke, cmd, clk_run, busy, ready};
    exp = {e_cke, e_cmd, e_clk, e_busy, e_rdy};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d at %0t: actual {cke,cmd,clk_run,busy,ready}=%b expected %b",
               req, $time, act, exp);
    end
  endtask

  task automatic step(input logic en, input logic ex, input logic idl);
    enter_req  = en;
    exit_req   = ex;
    banks_idle = idl;
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    enter_req = 1'b0; exit_req = 1'b0; banks_idle = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(1'b1, NOP, 1'b1, 1'b0, 1'b0, 1);   // R1 during reset
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1'b1, NOP, 1'b1, 1'b0, 1'b0, 1);   // R1 after release

    // vector table
    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < int'(VEC[i].reps); k++) begin
        step(VEC[i].en, VEC[i].ex, VEC[i].idl);
        check(VEC[i].cke, VEC[i].cmd, VEC[i].clkr, VEC[i].busy, VEC[i].rdy, int'(VEC[i].req));
        @(negedge clk);
      end
    end

    // directed: pending entry survives a long bank-busy stretch (R3)
    step(1'b1, 1'b0, 1'b0); @(negedge clk);
    for (int k = 0; k < 20; k++) begin step(1'b0, 1'b0, 1'b0); @(negedge clk); end
    check(1'b1, NOP, 1'b1, 1'b0, 1'b0, 3);
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, REF, 1'b1, 1'b1, 1'b0, 3);
    @(negedge clk);
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, DES, 1'b1, 1'b1, 1'b0, 4);
    @(negedge clk);
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, DES, 1'b0, 1'b1, 1'b0, 5);
    @(negedge clk);

    // directed: reset while asleep returns to the idle outputs (R1)
    rst_n = 1'b0;
    #1;
    check(1'b1, NOP, 1'b1, 1'b0, 1'b0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(1'b1, NOP, 1'b1, 1'b0, 1'b0, 1);
    step(1'b0, 1'b1, 1'b1);                  // R10 stray exit after reset
    check(1'b1, NOP, 1'b1, 1'b0, 1'b0, 10);
    @(negedge clk);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule